// File: doc/BRIEF.md
# Block-Transfer DMA Channel

This block is one DMA channel that works only in block transfer mode. Configuration arrives on plain input ports and is captured by a load strobe. Each accepted activation request moves one whole block of data units. A unit is a byte or a 16-bit word. Every unit is read from the source address and then written to the destination address, over a simple request/ready memory port.

One side, source or destination, is named the block area. After every block that side's address returns to its loaded start value, while the other side keeps stepping. The block-size counter reloads after every block, and the block count drops by one. When the count is used up, the channel disables itself and, if allowed, raises an end interrupt.

Activation comes from a vector of peripheral request lines. The channel watches the one line picked by the select field. It may also pulse a clear back to that peripheral at the end of each block.

Top module: `dmab_channel`

## Requirements
- R1: After reset, `bus_req`, `chan_en`, `end_irq` and every bit of `act_clr` are 0.
- R2: `cfg_load` is taken only while `chan_en` is 0. A taken load captures every `cfg_*` field and sets `chan_en` to `cfg_chan_en`. A load while `chan_en` is 1 changes nothing, and the running transfer keeps its old addresses.
- R3: A block starts only when `chan_en` and `master_en` are both 1 and a request is pending on `req_in[sel]`. Here `sel` is the loaded `cfg_req_sel`. Line index 0 is A/D end, 1 is external, 2 is serial transmit-empty, 3 is serial receive-full, and 4 to 9 are timer channels 0 to 5. Pulses on other lines are ignored. A request that arrives while `master_en` is 0 stays pending and is served once `master_en` rises.
- R4: A block is `cfg_blk_size` units long, and a size of 0 means 256 units. Each unit is one read (`bus_we`=0, address = source) followed by one write (`bus_we`=1, address = destination) that carries the data just read.
- R5: Each step field works as follows: 2'b01 increments, 2'b10 decrements, 2'b00 and 2'b11 hold. The step is 1 for bytes (`cfg_word`=0) and 2 for words (`cfg_word`=1). A word puts the lower address in bits 7:0.
- R6: At the end of each block, the block-area address returns to its loaded start. The destination is the block area when `cfg_blk_on_dst`=1, and the source otherwise. The other address keeps its stepped value.
- R7: The block count drops by one per block. When it reaches zero, `chan_en` clears. A count of 0 means 65536 blocks.
- R8: `end_irq` is set after the last block when `cfg_irq_en` was 1. It holds until the next taken load.
- R9: When `cfg_clr_en`=1, `act_clr[sel]` pulses for one cycle after each block and no other bit ever rises. When `cfg_clr_en`=0, it stays 0.
- R10: At most one request is held pending. Several pulses during a running block yield exactly one more block.
- R11: While `bus_req` is 1 and `bus_ready` is 0, the address, direction and write data hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load strobe for configuration |
| cfg_chan_en | input | 1 | Channel enable value to load |
| cfg_src_addr | input | AW | Source start address |
| cfg_dst_addr | input | AW | Destination start address |
| cfg_blk_size | input | BW | Units per block (0 = 256) |
| cfg_blk_count | input | CW | Number of blocks |
| cfg_word | input | 1 | 1 = word units, 0 = byte units |
| cfg_src_step | input | 2 | Source step mode |
| cfg_dst_step | input | 2 | Destination step mode |
| cfg_blk_on_dst | input | 1 | 1 = destination is the block area |
| cfg_req_sel | input | log2(NREQ) | Activation line select |
| cfg_irq_en | input | 1 | End interrupt enable |
| cfg_clr_en | input | 1 | Clear requester after each block |
| master_en | input | 1 | Master enable |
| req_in | input | NREQ | Peripheral request lines |
| act_clr | output | NREQ | Clear pulse back to the selected requester |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_word | output | 1 | Access is a word |
| bus_addr | output | AW | Access address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data |
| bus_ready | input | 1 | Access completes this cycle |
| chan_en | output | 1 | Channel enable state |
| end_irq | output | 1 | Transfer-end interrupt |

## Verification
The bench goes after the block-area snap-back on both sides. A design that restored the wrong side, or restored both, would leave bytes in the wrong memory cells. It checks a block size of 0: a design that treats it as empty would write nothing, and one that stops at 255 would leave the last cell unwritten. It also checks decrementing, fixed and word-stepped addresses. Several requests inside one block must give exactly one extra block, not zero and not several. A load while the channel runs must not redirect the writes, and a request held back by the master enable must still be served. Stalls on the bus must not drop or duplicate a unit.

// File: rtl/dmab_pkg.sv
package dmab_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } dma_state_e;

    typedef enum logic [1:0] {
        STEP_HOLD  = 2'b00,
        STEP_UP    = 2'b01,
        STEP_DOWN  = 2'b10,
        STEP_HOLD2 = 2'b11
    } step_mode_e;

    typedef struct packed {
        logic       word;
        step_mode_e src_mode;
        step_mode_e dst_mode;
        logic       blk_on_dst;
        logic       irq_en;
        logic       clr_en;
    } chan_mode_t;

    function automatic logic [31:0] step_addr(input logic [31:0] a,
                                              input step_mode_e m,
                                              input logic word);
        logic [31:0] d;
        d = word ? 32'd2 : 32'd1;
        case (m)
            STEP_UP:   return a + d;
            STEP_DOWN: return a - d;
            default:   return a;
        endcase
    endfunction

endpackage

// File: rtl/dmab_addr_unit.sv
module dmab_addr_unit
    import dmab_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  step_mode_e    mode,
    input  logic          word,
    input  logic          step,
    input  logic          restore,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] addr_q;
    logic [AW-1:0] start_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            start_q <= '0;
        end else if (load) begin
            addr_q  <= load_val;
            start_q <= load_val;
        end else if (restore) begin
            addr_q  <= start_q;
        end else if (step) begin
            addr_q  <= AW'(step_addr(32'(addr_q), mode, word));
        end
    end

    assign addr = addr_q;

    // R6: the block-area side lands on its start value after a block end
    a_r6_restore_start: assert property (@(posedge clk) disable iff (rst)
        (restore && !load) |=> (addr == start_q));
endmodule

// File: rtl/dmab_req_sel.sv
module dmab_req_sel #(
    parameter int NREQ = 16,
    localparam int SW  = $clog2(NREQ)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NREQ-1:0] req_in,
    input  logic [SW-1:0]   sel,
    input  logic            consume,
    output logic            pending
);
    logic pend_q;
    logic hit;

    assign hit = req_in[sel];

    always_ff @(posedge clk) begin
        if (rst) pend_q <= 1'b0;
        else     pend_q <= (pend_q && !consume) || hit;
    end

    assign pending = pend_q;

    // R10: a consumed request leaves nothing behind unless a new pulse came
    a_r10_single_pending: assert property (@(posedge clk) disable iff (rst)
        (consume && !hit) |=> !pending);
endmodule

// File: rtl/dmab_ctl.sv
module dmab_ctl
    import dmab_pkg::*;
#(
    parameter int BW = 8,
    parameter int CW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          load_chan_en,
    input  logic [BW-1:0] load_size,
    input  logic [CW-1:0] load_count,
    input  logic          irq_en,
    input  logic          clr_en,
    input  logic          master_en,
    input  logic          pending,
    input  logic          bus_ready,
    input  logic [DW-1:0] rdata,
    output logic [DW-1:0] wdata,
    output logic          in_read,
    output logic          in_write,
    output logic          consume,
    output logic          unit_done,
    output logic          blk_end,
    output logic          chan_en,
    output logic          end_irq,
    output logic          clr_pulse
);
    dma_state_e    st_q;
    logic [BW-1:0] size_ctr_q;
    logic [BW-1:0] size_rel_q;
    logic [CW-1:0] count_q;
    logic [DW-1:0] data_q;
    logic          en_q;
    logic          irq_q;
    logic          clr_q;
    logic          last_unit;

    assign consume   = (st_q == ST_IDLE) && en_q && master_en && pending;
    assign unit_done = (st_q == ST_WRITE) && bus_ready;
    assign last_unit = (size_ctr_q == BW'(1));
    assign blk_end   = unit_done && last_unit;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            size_ctr_q <= '0;
            size_rel_q <= '0;
            count_q    <= '0;
            data_q     <= '0;
            en_q       <= 1'b0;
            irq_q      <= 1'b0;
            clr_q      <= 1'b0;
        end else begin
            clr_q <= blk_end && clr_en;
            if (load) begin
                size_ctr_q <= load_size;
                size_rel_q <= load_size;
                count_q    <= load_count;
                en_q       <= load_chan_en;
                irq_q      <= 1'b0;
            end
            case (st_q)
                ST_IDLE: if (consume) st_q <= ST_READ;
                ST_READ: if (bus_ready) begin
                    data_q <= rdata;
                    st_q   <= ST_WRITE;
                end
                ST_WRITE: if (bus_ready) begin
                    st_q       <= last_unit ? ST_IDLE : ST_READ;
                    size_ctr_q <= last_unit ? size_rel_q : size_ctr_q - BW'(1);
                    if (last_unit) begin
                        count_q <= count_q - CW'(1);
                        if (count_q == CW'(1)) begin
                            en_q  <= 1'b0;
                            irq_q <= irq_en;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign wdata     = data_q;
    assign in_read   = (st_q == ST_READ);
    assign in_write  = (st_q == ST_WRITE);
    assign chan_en   = en_q;
    assign end_irq   = irq_q;
    assign clr_pulse = clr_q;

    // R3: no block begins while either enable is low
    a_r3_no_start_disabled: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && !(chan_en && master_en)) |=> (st_q == ST_IDLE));
    // R7: the enable only falls as a block finishes
    a_r7_en_falls_at_end: assert property (@(posedge clk) disable iff (rst)
        $fell(chan_en) |-> $past(blk_end));
    // R8: the end interrupt appears only with the channel disabled
    a_r8_irq_when_done: assert property (@(posedge clk) disable iff (rst)
        $rose(end_irq) |-> !chan_en);
endmodule

// File: rtl/dmab_channel.sv
module dmab_channel
    import dmab_pkg::*;
#(
    parameter int AW   = 16,
    parameter int NREQ = 16,
    parameter int BW   = 8,
    parameter int CW   = 16,
    parameter int DW   = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_load,
    input  logic                     cfg_chan_en,
    input  logic [AW-1:0]            cfg_src_addr,
    input  logic [AW-1:0]            cfg_dst_addr,
    input  logic [BW-1:0]            cfg_blk_size,
    input  logic [CW-1:0]            cfg_blk_count,
    input  logic                     cfg_word,
    input  logic [1:0]               cfg_src_step,
    input  logic [1:0]               cfg_dst_step,
    input  logic                     cfg_blk_on_dst,
    input  logic [$clog2(NREQ)-1:0]  cfg_req_sel,
    input  logic                     cfg_irq_en,
    input  logic                     cfg_clr_en,
    input  logic                     master_en,
    input  logic [NREQ-1:0]          req_in,
    output logic [NREQ-1:0]          act_clr,
    output logic                     bus_req,
    output logic                     bus_we,
    output logic                     bus_word,
    output logic [AW-1:0]            bus_addr,
    output logic [DW-1:0]            bus_wdata,
    input  logic [DW-1:0]            bus_rdata,
    input  logic                     bus_ready,
    output logic                     chan_en,
    output logic                     end_irq
);
    localparam int SW = $clog2(NREQ);

    chan_mode_t    mode_q;
    logic [SW-1:0] sel_q;
    logic          load_ok;
    logic          pending, consume, unit_done, blk_end, clr_pulse;
    logic          in_read, in_write;
    logic [AW-1:0] src_addr, dst_addr;

    assign load_ok = cfg_load && !chan_en && !bus_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            sel_q  <= '0;
        end else if (load_ok) begin
            mode_q.word       <= cfg_word;
            mode_q.src_mode   <= step_mode_e'(cfg_src_step);
            mode_q.dst_mode   <= step_mode_e'(cfg_dst_step);
            mode_q.blk_on_dst <= cfg_blk_on_dst;
            mode_q.irq_en     <= cfg_irq_en;
            mode_q.clr_en     <= cfg_clr_en;
            sel_q             <= cfg_req_sel;
        end
    end

    dmab_req_sel #(.NREQ(NREQ)) u_req (
        .clk(clk), .rst(rst), .req_in(req_in), .sel(sel_q),
        .consume(consume), .pending(pending)
    );

    dmab_ctl #(.BW(BW), .CW(CW), .DW(DW)) u_ctl (
        .clk(clk), .rst(rst), .load(load_ok), .load_chan_en(cfg_chan_en),
        .load_size(cfg_blk_size), .load_count(cfg_blk_count),
        .irq_en(mode_q.irq_en), .clr_en(mode_q.clr_en), .master_en(master_en),
        .pending(pending), .bus_ready(bus_ready), .rdata(bus_rdata),
        .wdata(bus_wdata), .in_read(in_read), .in_write(in_write),
        .consume(consume), .unit_done(unit_done), .blk_end(blk_end),
        .chan_en(chan_en), .end_irq(end_irq), .clr_pulse(clr_pulse)
    );

    dmab_addr_unit #(.AW(AW)) u_src (
        .clk(clk), .rst(rst), .load(load_ok), .load_val(cfg_src_addr),
        .mode(mode_q.src_mode), .word(mode_q.word), .step(unit_done),
        .restore(blk_end && !mode_q.blk_on_dst), .addr(src_addr)
    );

    dmab_addr_unit #(.AW(AW)) u_dst (
        .clk(clk), .rst(rst), .load(load_ok), .load_val(cfg_dst_addr),
        .mode(mode_q.dst_mode), .word(mode_q.word), .step(unit_done),
        .restore(blk_end && mode_q.blk_on_dst), .addr(dst_addr)
    );

    for (genvar i = 0; i < NREQ; i++) begin : g_clr
        assign act_clr[i] = clr_pulse && (sel_q == SW'(i));
    end

    assign bus_req  = in_read || in_write;
    assign bus_we   = in_write;
    assign bus_word = mode_q.word;
    assign bus_addr = in_write ? dst_addr : src_addr;

    // R11: a stalled access holds its address, direction and data
    a_r11_stall_stable: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr)
                                     && $stable(bus_we) && $stable(bus_wdata)));
    // R9: at most one requester is cleared at a time
    a_r9_clr_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(act_clr));
endmodule

// File: tb/tb_dmab_channel.sv
module tb_dmab_channel;
    localparam int AW = 8;
    localparam int NREQ = 16;

    typedef struct packed {
        logic [7:0] src;
        logic [7:0] dst;
        logic [7:0] size;
        logic [3:0] count;
        logic       word;
        logic [1:0] sm;
        logic [1:0] dm;
        logic       bdst;
        logic       irq;
        logic       clr;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{8'h10, 8'h80, 8'd4, 4'd3, 1'b0, 2'b01, 2'b01, 1'b0, 1'b1, 1'b1},
        '{8'h20, 8'h90, 8'd3, 4'd2, 1'b1, 2'b01, 2'b01, 1'b1, 1'b1, 1'b0},
        '{8'h60, 8'hC0, 8'd5, 4'd2, 1'b0, 2'b10, 2'b01, 1'b0, 1'b0, 1'b1},
        '{8'h30, 8'hA0, 8'd2, 4'd3, 1'b1, 2'b11, 2'b10, 1'b1, 1'b1, 1'b1},
        '{8'h00, 8'hE0, 8'd0, 4'd1, 1'b0, 2'b00, 2'b01, 1'b0, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic            cfg_load = 0, cfg_chan_en = 0, cfg_word = 0;
    logic [AW-1:0]   cfg_src_addr = 0, cfg_dst_addr = 0;
    logic [7:0]      cfg_blk_size = 0;
    logic [15:0]     cfg_blk_count = 0;
    logic [1:0]      cfg_src_step = 0, cfg_dst_step = 0;
    logic            cfg_blk_on_dst = 0, cfg_irq_en = 0, cfg_clr_en = 0;
    logic [3:0]      cfg_req_sel = 0;
    logic            master_en = 0;
    logic [NREQ-1:0] req_in = '0;
    logic [NREQ-1:0] act_clr;
    logic            bus_req, bus_we, bus_word, bus_ready, chan_en, end_irq;
    logic [AW-1:0]   bus_addr;
    logic [15:0]     bus_wdata, bus_rdata;

    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];
    logic       init_req = 0;
    logic       wait_en = 0;
    logic       tick = 0;
    int         wr_cnt = 0;
    int         clr_cnt = 0;
    logic [7:0] last_wr = 0;
    int         checks = 0;
    int         errors = 0;

    dmab_channel #(.AW(AW), .NREQ(NREQ)) dut (.*);

    logic [7:0] a1;
    assign a1 = bus_addr + 8'd1;
    assign bus_rdata = bus_word ? {mem[a1], mem[bus_addr]} : {8'h00, mem[bus_addr]};
    assign bus_ready = !wait_en || tick;

    function automatic logic [7:0] pat(input int i);
        return 8'(i * 7) ^ 8'h5A;
    endfunction

    always @(posedge clk) begin
        tick <= ~tick;
        if (init_req) begin
            for (int i = 0; i < 256; i++) mem[i] <= pat(i);
        end else if (bus_req && bus_we && bus_ready) begin
            mem[bus_addr] <= bus_wdata[7:0];
            if (bus_word) mem[a1] <= bus_wdata[15:8];
            wr_cnt  <= wr_cnt + 1;
            last_wr <= bus_addr;
        end
        if (act_clr != '0) clr_cnt <= clr_cnt + $countones(act_clr);
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic init_mem();
        init_req = 1; cyc(1); init_req = 0;
        for (int i = 0; i < 256; i++) exp_mem[i] = pat(i);
    endtask

    task automatic load(input vec_t v, input logic [3:0] sel, input logic en);
        cfg_src_addr = v.src; cfg_dst_addr = v.dst; cfg_blk_size = v.size;
        cfg_blk_count = 16'(v.count); cfg_word = v.word; cfg_src_step = v.sm;
        cfg_dst_step = v.dm; cfg_blk_on_dst = v.bdst; cfg_irq_en = v.irq;
        cfg_clr_en = v.clr; cfg_req_sel = sel; cfg_chan_en = en;
        cfg_load = 1; cyc(1); cfg_load = 0;
    endtask

    task automatic pulse(input int idx);
        req_in[idx] = 1'b1; cyc(1); req_in = '0;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        for (int k = 0; k < 3000 && quiet < 3; k++) begin
            cyc(1);
            quiet = bus_req ? 0 : quiet + 1;
        end
    endtask

    function automatic logic [7:0] st(input logic [7:0] a, input logic [1:0] m,
                                      input logic w);
        if (m == 2'b01) return a + (w ? 8'd2 : 8'd1);
        if (m == 2'b10) return a - (w ? 8'd2 : 8'd1);
        return a;
    endfunction

    task automatic model(input vec_t v);
        logic [7:0] s, d, b0, b1;
        int units;
        s = v.src; d = v.dst;
        units = (v.size == 0) ? 256 : int'(v.size);
        for (int b = 0; b < int'(v.count); b++) begin
            for (int u = 0; u < units; u++) begin
                b0 = exp_mem[s]; b1 = exp_mem[8'(s + 8'd1)];
                exp_mem[d] = b0;
                if (v.word) exp_mem[8'(d + 8'd1)] = b1;
                s = st(s, v.sm, v.word); d = st(d, v.dm, v.word);
            end
            if (v.bdst) d = v.dst; else s = v.src;
        end
    endtask

    function automatic int mem_diffs();
        int n = 0;
        for (int i = 0; i < 256; i++) if (mem[i] != exp_mem[i]) n++;
        return n;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R4 watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        vec_t v;
        int w0, c0, units;
        cyc(3);
        rst = 0;
        cyc(1);
        // R1 reset state
        chk("R1 bus_req", int'(bus_req), 0);
        chk("R1 chan_en", int'(chan_en), 0);
        chk("R1 end_irq", int'(end_irq), 0);
        chk("R1 act_clr", int'(act_clr), 0);
        master_en = 1;

        for (int i = 0; i < NV; i++) begin
            v = VECS[i];
            init_mem();
            model(v);
            w0 = wr_cnt; c0 = clr_cnt;
            load(v, 4'(i + 1), 1'b1);
            chk("R8 irq cleared by load", int'(end_irq), 0);
            chk("R2 load enables", int'(chan_en), 1);
            for (int b = 0; b < int'(v.count); b++) begin
                pulse(i + 1);
                wait_idle();
            end
            units = (v.size == 0) ? 256 : int'(v.size);
            chk("R4 write count", wr_cnt - w0, units * int'(v.count));
            chk("R5 R6 memory image", mem_diffs(), 0);
            chk("R7 channel off", int'(chan_en), 0);
            chk("R8 end irq", int'(end_irq), int'(v.irq));
            chk("R9 clear pulses", clr_cnt - c0, v.clr ? int'(v.count) : 0);
        end

        // R3 unselected line ignored, master enable gating
        init_mem();
        v = '{8'h08, 8'h48, 8'd2, 4'd1, 1'b0, 2'b01, 2'b01, 1'b0, 1'b0, 1'b0};
        w0 = wr_cnt;
        load(v, 4'd3, 1'b1);
        pulse(4);
        cyc(10);
        chk("R3 other line ignored", wr_cnt - w0, 0);
        master_en = 0;
        pulse(3);
        cyc(10);
        chk("R3 master low blocks", wr_cnt - w0, 0);
        master_en = 1;
        wait_idle();
        chk("R3 held request served", wr_cnt - w0, 2);
        chk("R7 single block done", int'(chan_en), 0);

        // R10 one pending request; R2 load ignored while running
        v = '{8'h10, 8'hD0, 8'd4, 4'd5, 1'b0, 2'b01, 2'b01, 1'b0, 1'b0, 1'b0};
        w0 = wr_cnt;
        load(v, 4'd2, 1'b1);
        pulse(2);
        cyc(1);
        pulse(2); cyc(1); pulse(2); cyc(1); pulse(2);
        wait_idle();
        chk("R10 one extra block", wr_cnt - w0, 8);
        chk("R10 channel still on", int'(chan_en), 1);
        v.dst = 8'h20;
        load(v, 4'd2, 1'b0);
        chk("R2 load ignored", int'(chan_en), 1);
        pulse(2);
        wait_idle();
        chk("R2 old destination kept", int'(last_wr), 8'hDB);

        // R11 stalled bus still moves every unit
        wait_en = 1;
        init_mem();
        v = '{8'h40, 8'h70, 8'd3, 4'd2, 1'b1, 2'b01, 2'b01, 1'b1, 1'b1, 1'b0};
        cyc(4);
        v.count = 4'd2;
        master_en = 1;
        // finish leftover blocks of the previous load first
        for (int k = 0; k < 2 && chan_en; k++) begin pulse(2); wait_idle(); end
        init_mem();
        model(v);
        w0 = wr_cnt;
        load(v, 4'd9, 1'b1);
        pulse(9); wait_idle();
        pulse(9); wait_idle();
        chk("R11 stalled writes", wr_cnt - w0, 6);
        chk("R11 stalled memory image", mem_diffs(), 0);
        wait_en = 0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule